// File: doc/BRIEF.md
# SONET Transmit Frame Sequencer

This block sits in the transmit path just ahead of a scrambler. The user drives a complete SONET frame into it as a stream of 32-bit words, one per word-clock cycle, with a one-cycle frame-start pulse on the first overhead word. The block follows the word's position within the frame by row and column. Every row has a fixed layout: a run of transport overhead words followed by a run of payload words. A frame is a fixed number of such rows. With the default sizes, 36 overhead words and 1044 payload words make one row, and nine rows make a frame of 9720 words, which is 125 µs at 77.76 MHz.

Each accepted word comes out one cycle later. It carries a start-of-frame marker and an overhead flag that are aligned to it. When the overwrite control is set, every word in an overhead column is replaced by a programmed pattern, and payload words pass through unchanged. A frame-start pulse that arrives away from the expected frame boundary realigns the position counters. It also sets a sticky misalignment flag.

Top module: `sonet_tx_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, out_valid, out_sof, out_oh and misalign are 0, and out_data is all zeros.
- R2: Every output is registered with exactly one cycle of latency. out_valid equals in_valid from the previous cycle. A payload word, or any word while overwrite is off, appears unchanged on out_data one cycle after it is accepted.
- R3: Once aligned, the first OH_COLS valid words of each row are flagged with out_oh=1 and the following SPE_COLS valid words are flagged with out_oh=0.
- R4: A frame is ROWS×(OH_COLS+SPE_COLS) valid words. After the last word of a frame the position wraps to row 0, column 0 even if no new frame-start pulse arrives, so N frames carry N×ROWS×OH_COLS overhead words.
- R5: out_sof is 1 exactly one cycle after a valid word accepted with in_sof=1, and that word is also flagged as overhead. An in_sof on a cycle with in_valid=0 is ignored.
- R6: When ovr_en=1 at acceptance, an overhead-column word leaves as ovr_pattern. With ovr_en=0 it leaves unchanged. Payload words are never replaced.
- R7: A valid in_sof at a position other than row 0, column 0 of the expected next frame resets the position to row 0, column 0 and sets misalign to 1. misalign then stays at 1 until reset. An in_sof at the expected boundary leaves misalign unchanged.
- R8: A cycle with in_valid=0 does not advance the position. It gives out_valid=0, out_sof=0 and out_oh=0, and out_data keeps its previous value.
- R9: Before the first valid in_sof after reset, the position is unknown. Words then leave with out_oh=0 and are never overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | DATA_W | Input frame word |
| in_sof | input | 1 | Frame start, on the first overhead word |
| ovr_en | input | 1 | Replace overhead words with the pattern |
| ovr_pattern | input | DATA_W | Replacement overhead word |
| out_valid | output | 1 | Output word present |
| out_data | output | DATA_W | Output frame word |
| out_sof | output | 1 | Output word starts a frame |
| out_oh | output | 1 | Output word is overhead |
| misalign | output | 1 | Sticky: a frame start arrived off boundary |

## Verification
The bench builds the block with ROWS=3, OH_COLS=4 and SPE_COLS=10, which gives 42-word frames. With a frame this short, the run can cover several frames that wrap without a frame-start pulse, frames with idle gaps, a full frame with overwrite on, and a misaligned frame start followed by a realigned frame, all within a few hundred cycles. The 32-bit width is the default, so the overwrite pattern and the pass-through data are checked at full width.

// File: rtl/sonet_seq_pkg.sv
package sonet_seq_pkg;
   typedef struct packed {
      logic valid;
      logic sof;
      logic oh;
   } word_tag_t;

   function automatic logic [31:0] clog2_min1(input int unsigned n);
      return (n < 2) ? 32'd1 : 32'($clog2(n));
   endfunction
endpackage

// File: rtl/sonet_pos_tracker.sv
module sonet_pos_tracker #(
   parameter int unsigned ROWS     = 9,
   parameter int unsigned OH_COLS  = 36,
   parameter int unsigned SPE_COLS = 1044
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_sof,
   output logic word_oh,
   output logic synced_now,
   output logic mis_q
);
   localparam int unsigned ROW_COLS = OH_COLS + SPE_COLS;
   localparam int unsigned COL_W    = sonet_seq_pkg::clog2_min1(ROW_COLS);
   localparam int unsigned ROW_W    = sonet_seq_pkg::clog2_min1(ROWS);

   logic [COL_W-1:0] col_q, cur_col;
   logic [ROW_W-1:0] row_q, cur_row;
   logic             synced_q;
   logic             col_last, row_last, off_boundary;

   always_comb begin
      cur_col      = in_sof ? '0 : col_q;
      cur_row      = in_sof ? '0 : row_q;
      synced_now   = synced_q | in_sof;
      word_oh      = synced_now && (cur_col < COL_W'(OH_COLS));
      col_last     = (cur_col == COL_W'(ROW_COLS - 1));
      row_last     = (cur_row == ROW_W'(ROWS - 1));
      off_boundary = synced_q && ((col_q != '0) || (row_q != '0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q    <= '0;
         row_q    <= '0;
         synced_q <= 1'b0;
         mis_q    <= 1'b0;
      end else if (in_valid) begin
         synced_q <= synced_now;
         if (synced_now) begin
            col_q <= col_last ? '0 : cur_col + COL_W'(1);
            if (col_last)
               row_q <= row_last ? '0 : cur_row + ROW_W'(1);
            else
               row_q <= cur_row;
         end
         if (in_sof && off_boundary)
            mis_q <= 1'b1;
      end
   end
endmodule

// File: rtl/sonet_oh_mux.sv
module sonet_oh_mux #(
   parameter int unsigned DATA_W   = 32,
   parameter bit          OVR_IMPL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic [DATA_W-1:0] in_data,
   input  logic              word_oh,
   input  logic              ovr_en,
   input  logic [DATA_W-1:0] ovr_pattern,
   output sonet_seq_pkg::word_tag_t tag_q,
   output logic [DATA_W-1:0] data_q
);
   logic [DATA_W-1:0] next_data;

   generate
      if (OVR_IMPL) begin : g_ovr
         always_comb next_data = (ovr_en && word_oh) ? ovr_pattern : in_data;
      end else begin : g_pass
         logic unused_ovr;
         always_comb begin
            unused_ovr = ovr_en ^ (^ovr_pattern);
            next_data  = in_data;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q  <= '0;
         data_q <= '0;
      end else begin
         tag_q.valid <= in_valid;
         tag_q.sof   <= in_valid && in_sof;
         tag_q.oh    <= in_valid && word_oh;
         if (in_valid)
            data_q <= next_data;
      end
   end
endmodule

// File: rtl/sonet_tx_seq.sv
module sonet_tx_seq #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ROWS     = 9,
   parameter int unsigned OH_COLS  = 36,
   parameter int unsigned SPE_COLS = 1044,
   parameter bit          OVR_IMPL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sof,
   input  logic              ovr_en,
   input  logic [DATA_W-1:0] ovr_pattern,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_oh,
   output logic              misalign
);
   generate
      if (DATA_W < 1)    begin : g_bad_width $error("DATA_W must be at least 1"); end
      if (ROWS < 2)      begin : g_bad_rows  $error("ROWS must be at least 2"); end
      if (OH_COLS < 1)   begin : g_bad_oh    $error("OH_COLS must be at least 1"); end
      if (SPE_COLS < 1)  begin : g_bad_spe   $error("SPE_COLS must be at least 1"); end
   endgenerate

   logic word_oh, synced_now;
   sonet_seq_pkg::word_tag_t tag;

   sonet_pos_tracker #(
      .ROWS(ROWS), .OH_COLS(OH_COLS), .SPE_COLS(SPE_COLS)
   ) u_pos (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .word_oh(word_oh), .synced_now(synced_now), .mis_q(misalign)
   );

   sonet_oh_mux #(
      .DATA_W(DATA_W), .OVR_IMPL(OVR_IMPL)
   ) u_mux (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_data(in_data), .word_oh(word_oh), .ovr_en(ovr_en),
      .ovr_pattern(ovr_pattern), .tag_q(tag), .data_q(out_data)
   );

   logic unused_sync;
   always_comb begin
      unused_sync = synced_now;
      out_valid   = tag.valid;
      out_sof     = tag.sof;
      out_oh      = tag.oh;
   end
endmodule

// File: rtl/sonet_tx_seq_chk.sv
module sonet_tx_seq_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter bit          OVR_IMPL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic              in_sof,
   input logic              ovr_en,
   input logic [DATA_W-1:0] ovr_pattern,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_sof,
   input logic              out_oh,
   input logic              misalign
);
   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_pass_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ovr_en) |=> (out_data == $past(in_data)));

   p_sof_marks_oh_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> (out_sof && out_oh));

   p_sof_has_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

   p_ovr_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (OVR_IMPL && in_valid && ovr_en) |=> (out_oh ? (out_data == $past(ovr_pattern)) : (out_data == $past(in_data))));

   p_misalign_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |=> misalign);

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_oh && !out_sof && $stable(out_data)));
endmodule

bind sonet_tx_seq sonet_tx_seq_chk #(.DATA_W(DATA_W), .OVR_IMPL(OVR_IMPL)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
   .in_sof(in_sof), .ovr_en(ovr_en), .ovr_pattern(ovr_pattern),
   .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
   .out_oh(out_oh), .misalign(misalign)
);

// File: tb/sonet_tx_seq_test.sv
module sonet_tx_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW   = 32;
   localparam int NR   = 3;
   localparam int NOH  = 4;
   localparam int NSPE = 10;
   localparam int RLEN = NOH + NSPE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0, ovr_en = 1'b0;
   logic [DW-1:0] in_data = '0, ovr_pattern = 32'hA5C3_0F96;
   logic out_valid, out_sof, out_oh, misalign;
   logic [DW-1:0] out_data;

   sonet_tx_seq #(.DATA_W(DW), .ROWS(NR), .OH_COLS(NOH), .SPE_COLS(NSPE)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_sof(in_sof), .ovr_en(ovr_en), .ovr_pattern(ovr_pattern),
      .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
      .out_oh(out_oh), .misalign(misalign)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0, n_fail = 0;
   int m_row = 0, m_col = 0;
   bit m_sync = 0, m_mis = 0;
   bit e_valid = 0, e_sof = 0, e_oh = 0;
   logic [DW-1:0] e_data = '0;
   int cnt_oh = 0, cnt_pl = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // one clock: drive at negedge, model, compare after the edge
   task automatic step(input bit v, input bit s, input logic [DW-1:0] d);
      bit oh;
      @(negedge clk);
      in_valid = v; in_sof = s; in_data = d;
      e_valid = v; e_sof = v && s; e_oh = 0;
      if (v) begin
         if (s) begin
            if (m_sync && (m_row != 0 || m_col != 0)) m_mis = 1;
            m_row = 0; m_col = 0; m_sync = 1;
         end
         oh = m_sync && (m_col < NOH);
         e_oh = oh;
         e_data = (ovr_en && oh) ? ovr_pattern : d;
         if (m_sync) begin
            m_col++;
            if (m_col == RLEN) begin
               m_col = 0; m_row++;
               if (m_row == NR) m_row = 0;
            end
         end
      end
      @(posedge clk); #1;
      chk(out_valid == e_valid, "R2/R8", "out_valid", DW'(out_valid), DW'(e_valid));
      chk(out_sof == e_sof, "R5", "out_sof", DW'(out_sof), DW'(e_sof));
      chk(out_oh == e_oh, "R3/R9", "out_oh", DW'(out_oh), DW'(e_oh));
      chk(out_data == e_data, "R6/R2", "out_data", out_data, e_data);
      chk(misalign == m_mis, "R7", "misalign", DW'(misalign), DW'(m_mis));
      if (out_valid && out_oh) cnt_oh++;
      if (out_valid && !out_oh) cnt_pl++;
   endtask

   task automatic run_frames(input int nf, input bit sof_each, input bit gaps);
      for (int w = 0; w < nf * NR * RLEN; w++) begin
         if (gaps && (w % 7 == 3)) step(0, 1, $urandom);  // sof without valid: ignored (R5, R8)
         step(1, sof_each && m_row == 0 && m_col == 0, $urandom);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(!out_valid && !out_sof && !out_oh && !misalign && out_data == '0, "R1",
          "reset outputs", {out_valid, out_sof, out_oh, misalign}, '0);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #1;
      chk(!out_valid && !misalign && out_data == '0, "R1", "after release",
          {out_valid, misalign}, '0);

      // R9: unaligned words, overwrite on but nothing replaced
      ovr_en = 1;
      for (int i = 0; i < 5; i++) step(1, 0, 32'h1000 + i);
      ovr_en = 0;

      // R3/R4: first frame aligned, second frame wraps without sof, gaps (R8)
      cnt_oh = 0; cnt_pl = 0;
      step(1, 1, 32'h5A5A_0001);
      run_frames(1, 0, 1);
      for (int i = 1; i < NR * RLEN; i++) step(1, 0, $urandom);
      run_frames(1, 1, 0);
      chk(cnt_oh == 3 * NR * NOH, "R4", "overhead count", cnt_oh, 3 * NR * NOH);
      chk(cnt_pl == 3 * NR * NSPE, "R4", "payload count", cnt_pl, 3 * NR * NSPE);
      chk(misalign == 0, "R7", "boundary sof keeps misalign", DW'(misalign), 0);

      // R6: overwrite on for two frames
      ovr_en = 1; cnt_oh = 0;
      run_frames(2, 1, 1);
      chk(cnt_oh == 2 * NR * NOH, "R6", "overwritten overhead count", cnt_oh, 2 * NR * NOH);
      ovr_pattern = 32'h0123_4567;
      run_frames(1, 0, 0);
      ovr_en = 0;

      // R7: off-boundary sof in payload, then realigned frame
      for (int i = 0; i < 9; i++) step(1, 0, $urandom);
      step(1, 1, 32'hDEAD_0007);
      chk(misalign == 1, "R7", "misalign set", DW'(misalign), 1);
      for (int i = 1; i < NR * RLEN; i++) step(1, 0, $urandom);
      run_frames(1, 1, 1);
      chk(misalign == 1, "R7", "misalign sticky", DW'(misalign), 1);

      step(0, 0, '0);
      finish_up();
   end
endmodule